// File: doc/BRIEF.md
# Calorimeter Jet Element Builder

This block takes paired energy words, one from the electromagnetic layer and one from the hadronic layer, for a set of calorimeter positions. It runs on a clock at twice the bunch-crossing rate. A strobe marks the fast cycle in which a new crossing's words are present.

Each layer word carries an odd parity bit, and each layer of each position has its own mask input. A word that is masked, or that fails parity, is replaced by zero. A parity failure on an unmasked word also sets a sticky error flag for that word.

The two cleaned words are added and clamped to the largest value an element can hold. The result is then sent downstream over a narrow path in two halves, one half per fast cycle. The low half goes first and the high half second. Every position has the same latency.

The output sequencer is a three-state machine:
- `S_IDLE`: outputs are zero and not valid.
- `S_LO`: the low halves are presented.
- `S_HI`: the high halves are presented.

Its transitions are:
- `T_START`: `S_IDLE` to `S_LO`, taken on the strobe.
- `T_SECOND`: `S_LO` to `S_HI`, always taken.
- `T_NEXT`: `S_HI` to `S_LO`, taken on the strobe.
- `T_STOP`: `S_HI` to `S_IDLE`, taken when there is no strobe.

Top module: `jet_elem_builder`

## Requirements
- R1: While reset (`rst_n` low) is applied and on the first cycle after it, `jet_vld_o` and `jet_hi_o` are 0, `jet_o` is all zero, and all error flags are 0.
- R2: For a position whose two words are unmasked, have good parity and are below their maximum, the element equals electromagnetic plus hadronic energy, provided the sum is below 2^JW-1.
- R3: The element is forced to 2^JW-1 (1023 by default, 1 GeV per count) in two cases: when the sum reaches or exceeds that value, or when either cleaned input word equals its own all-ones maximum.
- R4: Parity is odd: a word is good when its IW data bits plus its parity bit hold an odd number of ones. A word with bad parity contributes zero to the sum.
- R5: An error flag bit (`em_err_o[c]` / `had_err_o[c]`) is set when a crossing is accepted while that word has bad parity and is unmasked. Once set, it stays set until reset. A masked word, or a word that is not accepted, never sets it.
- R6: A word whose mask bit is 1 contributes zero to the sum, whatever its data and parity.
- R7: Suppose `bx_i` is high at a rising edge while the machine is in `S_IDLE` or `S_HI`. In the next cycle `jet_vld_o`=1 and `jet_hi_o`=0, and slice c of `jet_o` (bits c*HW+HW-1 down to c*HW) carries element bits HW-1:0. In the cycle after that, `jet_vld_o`=1 and `jet_hi_o`=1, and slice c carries element bits JW-1:HW, zero-padded.
- R8: A `bx_i` pulse seen in `S_LO` is ignored: it neither changes the high half that follows nor sets error flags. When `bx_i` is low at the end of `S_HI`, the machine returns to idle with `jet_vld_o`=0 and `jet_o` all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bx_i | input | 1 | New-crossing strobe |
| em_data_i | input | NCH*IW | Electromagnetic energies, position c at bits c*IW |
| em_par_i | input | NCH | Electromagnetic odd parity bits |
| had_data_i | input | NCH*IW | Hadronic energies |
| had_par_i | input | NCH | Hadronic odd parity bits |
| em_mask_i | input | NCH | 1 forces the electromagnetic word to zero |
| had_mask_i | input | NCH | 1 forces the hadronic word to zero |
| jet_o | output | NCH*HW | Element halves, HW=(JW+1)/2 |
| jet_vld_o | output | 1 | Halves on jet_o are valid |
| jet_hi_o | output | 1 | 1 when the high half is shown |
| em_err_o | output | NCH | Sticky electromagnetic parity error flags |
| had_err_o | output | NCH | Sticky hadronic parity error flags |

## Verification
Some properties are checked on every cycle:
- the state sequence low half, then high half, then either the next low half or idle;
- the all-zero idle output;
- the stickiness of the error flags, and that they do not change without a strobe.

The arithmetic needs the bench's scenarios:
- the sum itself, and the saturation at the sum boundary and at the input maximum;
- the zeroing of masked and parity-failing words;
- the masked-word exemption from flagging, and a strobe ignored in the low-half cycle.

// File: rtl/jeb_pkg.sv
package jeb_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LO   = 2'd1,
        S_HI   = 2'd2
    } ser_state_e;
endpackage

// File: rtl/jeb_chan_check.sv
module jeb_chan_check #(
    parameter int NCH = 12,
    parameter int IW  = 10
) (
    input  logic [NCH*IW-1:0] data_i,
    input  logic [NCH-1:0]    par_i,
    input  logic [NCH-1:0]    mask_i,
    output logic [NCH*IW-1:0] clean_o,
    output logic [NCH-1:0]    bad_o,
    output logic [NCH-1:0]    atmax_o
);
    localparam logic [IW-1:0] IMAX = {IW{1'b1}};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [IW-1:0] word;
        logic          par_ok;
        logic          keep;

        assign word    = data_i[c*IW +: IW];
        assign par_ok  = ^{par_i[c], word};
        assign keep    = par_ok && !mask_i[c];
        assign clean_o[c*IW +: IW] = keep ? word : '0;
        assign bad_o[c]   = !par_ok && !mask_i[c];
        assign atmax_o[c] = keep && (word == IMAX);
    end
endmodule

// File: rtl/jeb_elem_sum.sv
module jeb_elem_sum #(
    parameter int NCH = 12,
    parameter int IW  = 10,
    parameter int JW  = 10
) (
    input  logic [NCH*IW-1:0] em_i,
    input  logic [NCH*IW-1:0] had_i,
    input  logic [NCH-1:0]    em_max_i,
    input  logic [NCH-1:0]    had_max_i,
    output logic [NCH*JW-1:0] elem_o
);
    localparam int SW = ((IW > JW) ? IW : JW) + 1;
    localparam logic [SW-1:0] JMAX = SW'((64'd1 << JW) - 64'd1);

    for (genvar c = 0; c < NCH; c++) begin : g_sum
        logic [SW-1:0] sum;
        logic          sat;

        assign sum = SW'(em_i[c*IW +: IW]) + SW'(had_i[c*IW +: IW]);
        assign sat = (sum >= JMAX) || em_max_i[c] || had_max_i[c];
        assign elem_o[c*JW +: JW] = sat ? JMAX[JW-1:0] : sum[JW-1:0];
    end
endmodule

// File: rtl/jeb_ser_fsm.sv
module jeb_ser_fsm
    import jeb_pkg::*;
#(
    parameter int NCH = 12,
    parameter int JW  = 10,
    parameter int HW  = (JW + 1) / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bx_i,
    input  logic [NCH*JW-1:0] elem_i,
    output logic              accept_o,
    output logic [NCH*HW-1:0] jet_o,
    output logic              jet_vld_o,
    output logic              jet_hi_o
);
    localparam int PW = 2 * HW;

    ser_state_e        state_q;
    ser_state_e        state_d;
    logic [NCH*JW-1:0] elem_q;
    logic [NCH*HW-1:0] lo_half;
    logic [NCH*HW-1:0] hi_half;

    assign accept_o = bx_i && (state_q != S_LO);

    // next state: T_START, T_SECOND, T_NEXT, T_STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = bx_i ? S_LO : S_IDLE;
            S_LO:    state_d = S_HI;
            S_HI:    state_d = bx_i ? S_LO : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elem_q <= '0;
        end else if (accept_o) begin
            elem_q <= elem_i;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_split
        logic [PW-1:0] padded;
        assign padded = PW'(elem_q[c*JW +: JW]);
        assign lo_half[c*HW +: HW] = padded[HW-1:0];
        assign hi_half[c*HW +: HW] = padded[PW-1:HW];
    end

    always_comb begin
        jet_o     = '0;
        jet_vld_o = 1'b0;
        jet_hi_o  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                jet_o = '0;
            end
            S_LO: begin
                jet_o     = lo_half;
                jet_vld_o = 1'b1;
            end
            S_HI: begin
                jet_o     = hi_half;
                jet_vld_o = 1'b1;
                jet_hi_o  = 1'b1;
            end
            default: begin
                jet_o = '0;
            end
        endcase
    end
endmodule

// File: rtl/jet_elem_builder.sv
module jet_elem_builder #(
    parameter int NCH = 12,
    parameter int IW  = 10,
    parameter int JW  = 10,
    parameter int HW  = (JW + 1) / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bx_i,
    input  logic [NCH*IW-1:0] em_data_i,
    input  logic [NCH-1:0]    em_par_i,
    input  logic [NCH*IW-1:0] had_data_i,
    input  logic [NCH-1:0]    had_par_i,
    input  logic [NCH-1:0]    em_mask_i,
    input  logic [NCH-1:0]    had_mask_i,
    output logic [NCH*HW-1:0] jet_o,
    output logic              jet_vld_o,
    output logic              jet_hi_o,
    output logic [NCH-1:0]    em_err_o,
    output logic [NCH-1:0]    had_err_o
);
    logic [NCH*IW-1:0] em_clean;
    logic [NCH*IW-1:0] had_clean;
    logic [NCH-1:0]    em_bad;
    logic [NCH-1:0]    had_bad;
    logic [NCH-1:0]    em_max;
    logic [NCH-1:0]    had_max;
    logic [NCH*JW-1:0] elem;
    logic              accept;
    logic [NCH-1:0]    em_err_q;
    logic [NCH-1:0]    had_err_q;

    jeb_chan_check #(.NCH(NCH), .IW(IW)) u_em_chk (
        .data_i  (em_data_i),
        .par_i   (em_par_i),
        .mask_i  (em_mask_i),
        .clean_o (em_clean),
        .bad_o   (em_bad),
        .atmax_o (em_max)
    );

    jeb_chan_check #(.NCH(NCH), .IW(IW)) u_had_chk (
        .data_i  (had_data_i),
        .par_i   (had_par_i),
        .mask_i  (had_mask_i),
        .clean_o (had_clean),
        .bad_o   (had_bad),
        .atmax_o (had_max)
    );

    jeb_elem_sum #(.NCH(NCH), .IW(IW), .JW(JW)) u_sum (
        .em_i      (em_clean),
        .had_i     (had_clean),
        .em_max_i  (em_max),
        .had_max_i (had_max),
        .elem_o    (elem)
    );

    jeb_ser_fsm #(.NCH(NCH), .JW(JW), .HW(HW)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .bx_i      (bx_i),
        .elem_i    (elem),
        .accept_o  (accept),
        .jet_o     (jet_o),
        .jet_vld_o (jet_vld_o),
        .jet_hi_o  (jet_hi_o)
    );

    // sticky per-word parity flags, R5
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            em_err_q  <= '0;
            had_err_q <= '0;
        end else if (accept) begin
            em_err_q  <= em_err_q | em_bad;
            had_err_q <= had_err_q | had_bad;
        end
    end

    assign em_err_o  = em_err_q;
    assign had_err_o = had_err_q;
endmodule

// File: rtl/jeb_checker.sv
module jeb_checker #(
    parameter int NCH = 12,
    parameter int HW  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bx_i,
    input logic [NCH*HW-1:0] jet_o,
    input logic              jet_vld_o,
    input logic              jet_hi_o,
    input logic [NCH-1:0]    em_err_o,
    input logic [NCH-1:0]    had_err_o
);
    a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
        (bx_i && !(jet_vld_o && !jet_hi_o)) |=> (jet_vld_o && !jet_hi_o));

    a_r7_second: assert property (@(posedge clk) disable iff (!rst_n)
        (jet_vld_o && !jet_hi_o) |=> (jet_vld_o && jet_hi_o));

    a_r7_hi_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
        jet_hi_o |-> jet_vld_o);

    a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (jet_vld_o && jet_hi_o && !bx_i) |=> !jet_vld_o);

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !jet_vld_o |-> (jet_o == '0));

    a_r5_em_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((em_err_o & $past(em_err_o)) == $past(em_err_o)));

    a_r5_had_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((had_err_o & $past(had_err_o)) == $past(had_err_o)));

    a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bx_i |=> ($stable(em_err_o) && $stable(had_err_o)));
endmodule

bind jet_elem_builder jeb_checker #(.NCH(NCH), .HW(HW)) u_jeb_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bx_i      (bx_i),
    .jet_o     (jet_o),
    .jet_vld_o (jet_vld_o),
    .jet_hi_o  (jet_hi_o),
    .em_err_o  (em_err_o),
    .had_err_o (had_err_o)
);

// File: tb/sim_jet_elem_builder.sv
module sim_jet_elem_builder;
    localparam int NCH = 12;
    localparam int IW  = 10;
    localparam int JW  = 10;
    localparam int HW  = 5;
    localparam int NV  = 14;

    // row: [33:24] em, [23:14] had, [13] em parity flip, [12] had parity flip,
    //      [11] em mask, [10] had mask, [9:0] expected element
    localparam logic [33:0] VEC [NV] = '{
        {10'd0,    10'd0,    4'b0000, 10'd0},    // R2 zero
        {10'd5,    10'd7,    4'b0000, 10'd12},   // R2
        {10'd500,  10'd400,  4'b0000, 10'd900},  // R2
        {10'd600,  10'd423,  4'b0000, 10'd1023}, // R3 sum at ceiling
        {10'd600,  10'd500,  4'b0000, 10'd1023}, // R3 overflow
        {10'd1023, 10'd0,    4'b0000, 10'd1023}, // R3 em at max
        {10'd0,    10'd1023, 4'b0000, 10'd1023}, // R3 had at max
        {10'd300,  10'd200,  4'b1000, 10'd200},  // R4 em bad parity
        {10'd300,  10'd200,  4'b0100, 10'd300},  // R4 had bad parity
        {10'd300,  10'd200,  4'b0010, 10'd200},  // R6 em masked
        {10'd300,  10'd200,  4'b0001, 10'd300},  // R6 had masked
        {10'd1023, 10'd1023, 4'b0011, 10'd0},    // R6 both masked at max
        {10'd31,   10'd32,   4'b0000, 10'd63},   // R7 half boundary
        {10'd1023, 10'd5,    4'b1000, 10'd5}     // R4 bad word at max, no R3
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bx_i = 1'b0;
    logic [NCH*IW-1:0] em_data_i = '0;
    logic [NCH-1:0]    em_par_i = '0;
    logic [NCH*IW-1:0] had_data_i = '0;
    logic [NCH-1:0]    had_par_i = '0;
    logic [NCH-1:0]    em_mask_i = '0;
    logic [NCH-1:0]    had_mask_i = '0;
    logic [NCH*HW-1:0] jet_o;
    logic              jet_vld_o;
    logic              jet_hi_o;
    logic [NCH-1:0]    em_err_o;
    logic [NCH-1:0]    had_err_o;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    jet_elem_builder #(.NCH(NCH), .IW(IW), .JW(JW), .HW(HW)) u0 (
        .clk(clk), .rst_n(rst_n), .bx_i(bx_i),
        .em_data_i(em_data_i), .em_par_i(em_par_i),
        .had_data_i(had_data_i), .had_par_i(had_par_i),
        .em_mask_i(em_mask_i), .had_mask_i(had_mask_i),
        .jet_o(jet_o), .jet_vld_o(jet_vld_o), .jet_hi_o(jet_hi_o),
        .em_err_o(em_err_o), .had_err_o(had_err_o)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic set_word(input int c, input logic [IW-1:0] em, input logic [IW-1:0] had,
                            input logic ef, input logic hf, input logic em_m, input logic had_m);
        em_data_i[c*IW +: IW]  = em;
        had_data_i[c*IW +: IW] = had;
        em_par_i[c]   = ~(^em) ^ ef;
        had_par_i[c]  = ~(^had) ^ hf;
        em_mask_i[c]  = em_m;
        had_mask_i[c] = had_m;
    endtask

    task automatic set_all(input logic [IW-1:0] em, input logic [IW-1:0] had,
                           input logic ef, input logic hf, input logic em_m, input logic had_m);
        for (int c = 0; c < NCH; c++) set_word(c, em, had, ef, hf, em_m, had_m);
    endtask

    task automatic check_halves(input string tag, input logic [JW-1:0] exp, input logic hi);
        check({tag, " vld"}, 64'(jet_vld_o), 64'd1);
        check({tag, " hi"}, 64'(jet_hi_o), 64'(hi));
        for (int c = 0; c < NCH; c++)
            check(tag, 64'(jet_o[c*HW +: HW]), hi ? 64'(exp[JW-1:HW]) : 64'(exp[HW-1:0]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 vld", 64'(jet_vld_o), 64'd0);
        check("R1 hi", 64'(jet_hi_o), 64'd0);
        check("R1 jet", 64'(jet_o), 64'd0);
        check("R1 em_err", 64'(em_err_o), 64'd0);
        check("R1 had_err", 64'(had_err_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 64'(jet_vld_o), 64'd0);

        // table walk: channel c gets row (i+c) mod NV
        for (int i = 0; i < NV; i++) begin
            for (int c = 0; c < NCH; c++) begin
                logic [33:0] v;
                v = VEC[(i + c) % NV];
                set_word(c, v[33:24], v[23:14], v[13], v[12], v[11], v[10]);
            end
            bx_i = 1'b1;
            @(negedge clk);
            bx_i = 1'b0;
            check("R7 lo vld", 64'(jet_vld_o), 64'd1);
            check("R7 lo hi", 64'(jet_hi_o), 64'd0);
            for (int c = 0; c < NCH; c++)
                check("R2/R3/R4/R6/R7 low half", 64'(jet_o[c*HW +: HW]),
                      64'(VEC[(i + c) % NV][4:0]));
            @(negedge clk);
            check("R7 hi flag", 64'(jet_hi_o), 64'd1);
            for (int c = 0; c < NCH; c++)
                check("R2/R3/R4/R6/R7 high half", 64'(jet_o[c*HW +: HW]),
                      64'(VEC[(i + c) % NV][9:5]));
        end
        // every channel saw the em- and had-parity rows unmasked
        check("R5 em flags set", 64'(em_err_o), 64'({NCH{1'b1}}));
        check("R5 had flags set", 64'(had_err_o), 64'({NCH{1'b1}}));

        // R8: strobe during low half ignored, then stop to idle
        set_all(10'd100, 10'd20, 1'b0, 1'b0, 1'b0, 1'b0);
        bx_i = 1'b1;
        @(negedge clk);
        check_halves("R8 low of kept crossing", 10'd120, 1'b0);
        set_all(10'd7, 10'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        bx_i = 1'b1;
        @(negedge clk);
        bx_i = 1'b0;
        check_halves("R8 high not replaced", 10'd120, 1'b1);
        @(negedge clk);
        check("R8 idle vld", 64'(jet_vld_o), 64'd0);
        check("R8 idle jet", 64'(jet_o), 64'd0);

        // R1 reset clears sticky flags
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 flags cleared em", 64'(em_err_o), 64'd0);
        check("R1 flags cleared had", 64'(had_err_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: bad parity without strobe does not flag
        set_all(10'd9, 10'd9, 1'b1, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        @(negedge clk);
        check("R5 no strobe em", 64'(em_err_o), 64'd0);
        check("R5 no strobe had", 64'(had_err_o), 64'd0);

        // R5/R6: masked bad word does not flag and contributes zero
        set_all(10'd400, 10'd33, 1'b1, 1'b0, 1'b1, 1'b0);
        bx_i = 1'b1;
        @(negedge clk);
        bx_i = 1'b0;
        check_halves("R6 masked bad em low", 10'd33, 1'b0);
        @(negedge clk);
        check_halves("R6 masked bad em high", 10'd33, 1'b1);
        check("R5 masked no flag em", 64'(em_err_o), 64'd0);
        check("R5 masked no flag had", 64'(had_err_o), 64'd0);

        // R3 boundary below and at ceiling, back to back via T_NEXT
        set_all(10'd1022, 10'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        bx_i = 1'b1;
        @(negedge clk);
        bx_i = 1'b0;
        check_halves("R3 just below ceiling low", 10'd1022, 1'b0);
        @(negedge clk);
        check_halves("R3 just below ceiling high", 10'd1022, 1'b1);
        set_all(10'd1022, 10'd1, 1'b0, 1'b0, 1'b0, 1'b0);
        bx_i = 1'b1;
        @(negedge clk);
        bx_i = 1'b0;
        check_halves("R3 at ceiling low", 10'd1023, 1'b0);
        @(negedge clk);
        check_halves("R3 at ceiling high", 10'd1023, 1'b1);
        set_all(10'd900, 10'd900, 1'b0, 1'b0, 1'b0, 1'b0);
        bx_i = 1'b1;
        @(negedge clk);
        bx_i = 1'b0;
        check_halves("R3 large overflow low", 10'd1023, 1'b0);
        @(negedge clk);
        check_halves("R3 large overflow high", 10'd1023, 1'b1);
        @(negedge clk);
        check("R8 final idle", 64'(jet_vld_o), 64'd0);

        summary();
    end
endmodule